// File: doc/BRIEF.md
# Host Interface Register File

This block is the register front end of a programmable DMA engine. It sits between a host CPU and the small microprocessor that runs the transfer program. The host reaches it over a Wishbone slave port. The microprocessor reaches it through a simple single-cycle request port. Both sides see the same set of registers:

- sixteen 32-bit mailbox words, whose meaning is set entirely by the loaded program;
- a run-control word, whose bit 0 releases the microprocessor from reset;
- a latched interrupt-input word;
- an interrupt-output word that drives a single interrupt line toward the host.

The host address space has two halves. The upper half is a window onto the microprocessor's program memory, which lives outside this block. That window opens only while the microprocessor is held in reset. At other times the block acknowledges host accesses to the window, but they do not reach the memory. System interrupt lines are never delivered to the core. Their rising edges are latched into a word that the program polls.

Top module: `hir_regfile`

## Requirements
- R1: After reset all mailbox words, the run-control word and both interrupt words read 0, `cpu_rst_o` is 1 and `irq_o` is 0.
- R2: A host access to register space is acknowledged with `wb_ack_o` high in the cycle after the strobe is first seen. The read data is valid in that acknowledge cycle. A write takes effect at the first edge of the strobe.
- R3: Mailbox words at register indices 0..15 are read and written by both ports. A value written by one port is read back by either port.
- R4: When both ports write the same mailbox word in the same cycle, the processor-port value is kept.
- R5: Host register index 16 is run control. Writing bit 0 = 1 drives `cpu_rst_o` low from the next cycle, and writing 0 drives it high again. Only bit 0 reads back; the other bits read 0.
- R6: While `cpu_rst_o` is 1, a host access with address bit 10 set is forwarded to program memory at word address `wb_adr_i[9:0]`, with `pm_en_o` high in the strobe's first cycle. Read data is taken from `pm_rdata_i` during the acknowledge cycle.
- R7: While `cpu_rst_o` is 0, host program-memory accesses are still acknowledged. `pm_en_o` stays low, so nothing is written, and the read data is 0.
- R8: Register index 17 holds one flag per interrupt input. A flag is set in the cycle after a 0-to-1 change of its input and stays set after the input falls. An input held high does not set its flag again.
- R9: Writing 1 to a bit of index 17 from either port clears that flag. If a clear and a new rising edge of the same bit meet in one cycle, the flag is set.
- R10: A processor write to index 18 ORs its low 8 bits into the interrupt-output word. `irq_o` is high whenever any bit of that word is 1.
- R11: A host write to index 18 clears each bit written as 1. Bits written as 0 are unchanged.
- R12: Processor writes to run control have no effect. Register indices 19..31, and register-space host addresses with any of bits 9..5 set, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Host bus cycle |
| wb_stb_i | input | 1 | Host strobe |
| wb_we_i | input | 1 | Host write enable |
| wb_adr_i | input | 11 | Host word address; bit 10 selects program memory |
| wb_dat_i | input | 32 | Host write data |
| wb_ack_o | output | 1 | Host acknowledge |
| wb_dat_o | output | 32 | Host read data |
| pr_req_i | input | 1 | Processor access request, one cycle |
| pr_we_i | input | 1 | Processor write enable |
| pr_idx_i | input | 5 | Processor register index |
| pr_wdata_i | input | 32 | Processor write data |
| pr_ack_o | output | 1 | Processor acknowledge, one cycle after request |
| pr_rdata_o | output | 32 | Processor read data, valid with acknowledge |
| pm_en_o | output | 1 | Program memory access enable |
| pm_we_o | output | 1 | Program memory write enable |
| pm_addr_o | output | 10 | Program memory word address |
| pm_wdata_o | output | 32 | Program memory write data |
| pm_rdata_i | input | 32 | Program memory read data, one cycle after enable |
| irq_i | input | 8 | System interrupt inputs |
| irq_o | output | 1 | Interrupt toward the host |
| cpu_rst_o | output | 1 | Holds the microprocessor in reset |

## Verification
The mailbox words are exercised with a seeded random mix of host and processor reads and writes at random indices. This shows whether the two ports truly share storage and do not keep separate copies. A directed same-cycle write collision shows which port has priority.

Program-memory traffic is tried twice: once with the core in reset and once with it running. The second case distinguishes a window that is truly shut from one that only hides its read data, because a read taken after reset is reasserted must return the old value.

Interrupt inputs are driven with three patterns:
- a single-cycle pulse, which tells edge capture from level tracking;
- a held level that is cleared, which tells sticky edges from re-arming levels;
- a clear that lands on a fresh edge, which exposes set/clear priority.

// File: rtl/hir_pkg.sv
package hir_pkg;
  // Default geometry of the register file
  localparam int unsigned NMB_DEF  = 16;
  localparam int unsigned DW_DEF   = 32;
  localparam int unsigned NIRQ_DEF = 8;
  localparam int unsigned PAW_DEF  = 10;

  // Index of the first register after the mailboxes, plus the index width
  function automatic int unsigned idx_width(input int unsigned nmb);
    return $clog2(nmb + 3);
  endfunction

  // What the host acknowledge in flight returns
  typedef enum logic [1:0] {
    ACK_REG     = 2'd0,
    ACK_PM_OPEN = 2'd1,
    ACK_PM_SHUT = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/hir_mailbox.sv
module hir_mailbox #(
  parameter int unsigned NMB = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned IW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_we,
  input  logic [IW-1:0]     h_idx,
  input  logic [DW-1:0]     h_wdata,
  input  logic              p_we,
  input  logic [IW-1:0]     p_idx,
  input  logic [DW-1:0]     p_wdata,
  output logic [NMB*DW-1:0] words
);
  for (genvar g = 0; g < NMB; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (p_we && (p_idx == IW'(g))) begin
        // processor side has priority on a collision
        word_q <= p_wdata;
      end else if (h_we && (h_idx == IW'(g))) begin
        word_q <= h_wdata;
      end
    end
    assign words[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/hir_irq.sv
module hir_irq #(
  parameter int unsigned NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic [NIRQ-1:0] in_clr_h,
  input  logic [NIRQ-1:0] in_clr_p,
  input  logic [NIRQ-1:0] out_set_p,
  input  logic [NIRQ-1:0] out_clr_h,
  output logic [NIRQ-1:0] in_flags,
  output logic [NIRQ-1:0] out_flags
);
  logic [NIRQ-1:0] prev_q;
  logic [NIRQ-1:0] in_q;
  logic [NIRQ-1:0] out_q;
  logic [NIRQ-1:0] rise;

  assign rise = irq_lines & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      prev_q <= irq_lines;
      // a fresh edge beats a clear in the same cycle
      in_q   <= (in_q & ~(in_clr_h | in_clr_p)) | rise;
      out_q  <= (out_q & ~out_clr_h) | out_set_p;
    end
  end

  assign in_flags  = in_q;
  assign out_flags = out_q;
endmodule

// File: rtl/hir_host_port.sv
module hir_host_port
  import hir_pkg::*;
#(
  parameter int unsigned PAW = 10,
  parameter int unsigned IW  = 5,
  parameter int unsigned DW  = 32,
  localparam int unsigned HAW = PAW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wb_cyc,
  input  logic           wb_stb,
  input  logic           wb_we,
  input  logic [HAW-1:0] wb_adr,
  input  logic [DW-1:0]  wb_dat_i,
  output logic           wb_ack,
  output logic [DW-1:0]  wb_dat_o,
  input  logic           held,
  input  logic [DW-1:0]  reg_rdata,
  output logic           reg_wr,
  output logic [IW-1:0]  reg_idx,
  output logic [DW-1:0]  reg_wdata,
  output logic           pm_en,
  output logic           pm_we,
  output logic [PAW-1:0] pm_addr,
  output logic [DW-1:0]  pm_wdata,
  input  logic [DW-1:0]  pm_rdata
);
  logic          ack_q;
  ack_kind_e     kind_q;
  logic [DW-1:0] rdata_q;
  logic          new_req;
  logic          pm_space;
  logic          reg_hit;

  assign new_req  = wb_cyc & wb_stb & ~ack_q;
  assign pm_space = wb_adr[HAW-1];
  assign reg_hit  = ~pm_space && ((wb_adr[PAW-1:0] >> IW) == '0);

  assign reg_idx   = wb_adr[IW-1:0];
  assign reg_wr    = new_req & reg_hit & wb_we;
  assign reg_wdata = wb_dat_i;

  // program memory window only opens while the core is held in reset
  assign pm_en    = new_req & pm_space & held;
  assign pm_we    = pm_en & wb_we;
  assign pm_addr  = wb_adr[PAW-1:0];
  assign pm_wdata = wb_dat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      kind_q  <= ACK_REG;
      rdata_q <= '0;
    end else begin
      ack_q <= new_req;
      if (new_req) begin
        if (!pm_space)  kind_q <= ACK_REG;
        else if (held)  kind_q <= ACK_PM_OPEN;
        else            kind_q <= ACK_PM_SHUT;
        rdata_q <= reg_hit ? reg_rdata : '0;
      end
    end
  end

  always_comb begin
    unique case (kind_q)
      ACK_PM_OPEN: wb_dat_o = pm_rdata;
      ACK_PM_SHUT: wb_dat_o = '0;
      default:     wb_dat_o = rdata_q;
    endcase
  end

  assign wb_ack = ack_q;
endmodule

// File: rtl/hir_regfile.sv
module hir_regfile
  import hir_pkg::*;
#(
  parameter int unsigned NMB  = NMB_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned NIRQ = NIRQ_DEF,
  parameter int unsigned PAW  = PAW_DEF,
  localparam int unsigned HAW = PAW + 1,
  localparam int unsigned IW  = idx_width(NMB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wb_cyc_i,
  input  logic            wb_stb_i,
  input  logic            wb_we_i,
  input  logic [HAW-1:0]  wb_adr_i,
  input  logic [DW-1:0]   wb_dat_i,
  output logic            wb_ack_o,
  output logic [DW-1:0]   wb_dat_o,
  input  logic            pr_req_i,
  input  logic            pr_we_i,
  input  logic [IW-1:0]   pr_idx_i,
  input  logic [DW-1:0]   pr_wdata_i,
  output logic            pr_ack_o,
  output logic [DW-1:0]   pr_rdata_o,
  output logic            pm_en_o,
  output logic            pm_we_o,
  output logic [PAW-1:0]  pm_addr_o,
  output logic [DW-1:0]   pm_wdata_o,
  input  logic [DW-1:0]   pm_rdata_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic            irq_o,
  output logic            cpu_rst_o
);
  localparam logic [IW-1:0] I_CTRL = IW'(NMB);
  localparam logic [IW-1:0] I_IN   = IW'(NMB + 1);
  localparam logic [IW-1:0] I_OUT  = IW'(NMB + 2);

  logic [NMB*DW-1:0] mbox_flat;
  logic              run_q;
  logic [NIRQ-1:0]   irq_in_q;
  logic [NIRQ-1:0]   irq_out_q;

  logic              h_wr;
  logic [IW-1:0]     h_idx;
  logic [DW-1:0]     h_wdata;
  logic [DW-1:0]     h_rdata;

  logic              p_wr;
  logic              pr_ack_q;
  logic [DW-1:0]     pr_rdata_q;

  function automatic logic [DW-1:0] read_reg(input logic [IW-1:0] idx);
    logic [DW-1:0] v;
    v = '0;
    if (idx < I_CTRL)      v = mbox_flat[idx*DW +: DW];
    else if (idx == I_CTRL) v = DW'(run_q);
    else if (idx == I_IN)   v = DW'(irq_in_q);
    else if (idx == I_OUT)  v = DW'(irq_out_q);
    return v;
  endfunction

  // ---------------- host side ----------------
  hir_host_port #(.PAW(PAW), .IW(IW), .DW(DW)) u_host (
    .clk       (clk),
    .rst       (rst),
    .wb_cyc    (wb_cyc_i),
    .wb_stb    (wb_stb_i),
    .wb_we     (wb_we_i),
    .wb_adr    (wb_adr_i),
    .wb_dat_i  (wb_dat_i),
    .wb_ack    (wb_ack_o),
    .wb_dat_o  (wb_dat_o),
    .held      (~run_q),
    .reg_rdata (h_rdata),
    .reg_wr    (h_wr),
    .reg_idx   (h_idx),
    .reg_wdata (h_wdata),
    .pm_en     (pm_en_o),
    .pm_we     (pm_we_o),
    .pm_addr   (pm_addr_o),
    .pm_wdata  (pm_wdata_o),
    .pm_rdata  (pm_rdata_i)
  );

  assign h_rdata = read_reg(h_idx);

  // ---------------- processor side ----------------
  assign p_wr = pr_req_i & pr_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_ack_q   <= 1'b0;
      pr_rdata_q <= '0;
    end else begin
      pr_ack_q <= pr_req_i;
      if (pr_req_i) pr_rdata_q <= read_reg(pr_idx_i);
    end
  end

  assign pr_ack_o   = pr_ack_q;
  assign pr_rdata_o = pr_rdata_q;

  // ---------------- run control ----------------
  always_ff @(posedge clk) begin
    if (rst)                          run_q <= 1'b0;
    else if (h_wr && h_idx == I_CTRL) run_q <= h_wdata[0];
  end

  assign cpu_rst_o = ~run_q;

  // ---------------- storage ----------------
  hir_mailbox #(.NMB(NMB), .DW(DW), .IW(IW)) u_mbox (
    .clk     (clk),
    .rst     (rst),
    .h_we    (h_wr && (h_idx < I_CTRL)),
    .h_idx   (h_idx),
    .h_wdata (h_wdata),
    .p_we    (p_wr && (pr_idx_i < I_CTRL)),
    .p_idx   (pr_idx_i),
    .p_wdata (pr_wdata_i),
    .words   (mbox_flat)
  );

  hir_irq #(.NIRQ(NIRQ)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_i),
    .in_clr_h  ((h_wr && h_idx == I_IN)     ? h_wdata[NIRQ-1:0]    : '0),
    .in_clr_p  ((p_wr && pr_idx_i == I_IN)  ? pr_wdata_i[NIRQ-1:0] : '0),
    .out_set_p ((p_wr && pr_idx_i == I_OUT) ? pr_wdata_i[NIRQ-1:0] : '0),
    .out_clr_h ((h_wr && h_idx == I_OUT)    ? h_wdata[NIRQ-1:0]    : '0),
    .in_flags  (irq_in_q),
    .out_flags (irq_out_q)
  );

  assign irq_o = |irq_out_q;
endmodule

// File: rtl/hir_regfile_chk.sv
module hir_regfile_chk #(
  parameter int unsigned NMB  = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned NIRQ = 8,
  parameter int unsigned PAW  = 10,
  parameter int unsigned IW   = 5,
  localparam int unsigned HAW = PAW + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_cyc_i,
  input logic              wb_stb_i,
  input logic              wb_we_i,
  input logic [HAW-1:0]    wb_adr_i,
  input logic              wr_bit0,
  input logic              wb_ack_o,
  input logic [DW-1:0]     wb_dat_o,
  input logic              pr_req_i,
  input logic              pr_we_i,
  input logic [IW-1:0]     pr_idx_i,
  input logic [DW-1:0]     pr_wdata_i,
  input logic              pm_en_o,
  input logic [NIRQ-1:0]   irq_i,
  input logic              irq_o,
  input logic              cpu_rst_o,
  input logic [NMB*DW-1:0] mbox_flat,
  input logic [NIRQ-1:0]   irq_in_flags
);
  logic            h_new;
  logic            collide;
  logic            col_q;
  logic [IW-1:0]   col_idx_q;
  logic [DW-1:0]   col_data_q;
  logic [NIRQ-1:0] seen_q;
  logic [NIRQ-1:0] rise;

  assign h_new   = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign collide = h_new && wb_we_i && !wb_adr_i[HAW-1] &&
                   (wb_adr_i[HAW-2:0] == (HAW-1)'(pr_idx_i)) &&
                   pr_req_i && pr_we_i && (pr_idx_i < IW'(NMB));
  assign rise    = irq_i & ~seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= 1'b0;
      col_idx_q  <= '0;
      col_data_q <= '0;
      seen_q     <= '0;
    end else begin
      col_q      <= collide;
      col_idx_q  <= pr_idx_i;
      col_data_q <= pr_wdata_i;
      seen_q     <= irq_i;
    end
  end

  p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    h_new |=> wb_ack_o);

  p_ack_has_req_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  p_proc_wins_r4: assert property (@(posedge clk) disable iff (rst)
    col_q |-> (mbox_flat[col_idx_q*DW +: DW] == col_data_q));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (h_new && wb_we_i && !wb_adr_i[HAW-1] &&
     (wb_adr_i[HAW-2:0] == (HAW-1)'(NMB)) && wr_bit0) |=> !cpu_rst_o);

  p_pm_gate_r7: assert property (@(posedge clk) disable iff (rst)
    pm_en_o |-> cpu_rst_o);

  p_pm_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (h_new && !wb_we_i && wb_adr_i[HAW-1] && !cpu_rst_o) |=> (wb_dat_o == '0));

  p_irq_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((irq_in_flags & $past(rise)) == $past(rise)));

  p_irq_out_r10: assert property (@(posedge clk) disable iff (rst)
    (pr_req_i && pr_we_i && (pr_idx_i == IW'(NMB + 2)) &&
     (pr_wdata_i[NIRQ-1:0] != '0)) |=> irq_o);
endmodule

bind hir_regfile hir_regfile_chk #(
  .NMB(NMB), .DW(DW), .NIRQ(NIRQ), .PAW(PAW), .IW(IW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wb_cyc_i     (wb_cyc_i),
  .wb_stb_i     (wb_stb_i),
  .wb_we_i      (wb_we_i),
  .wb_adr_i     (wb_adr_i),
  .wr_bit0      (wb_dat_i[0]),
  .wb_ack_o     (wb_ack_o),
  .wb_dat_o     (wb_dat_o),
  .pr_req_i     (pr_req_i),
  .pr_we_i      (pr_we_i),
  .pr_idx_i     (pr_idx_i),
  .pr_wdata_i   (pr_wdata_i),
  .pm_en_o      (pm_en_o),
  .irq_i        (irq_i),
  .irq_o        (irq_o),
  .cpu_rst_o    (cpu_rst_o),
  .mbox_flat    (mbox_flat),
  .irq_in_flags (irq_in_q)
);

// File: tb/hir_regfile_tb.sv
module hir_regfile_tb;
  localparam int PAW = 10;
  localparam int HAW = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [10:0] wb_adr = '0;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack;
  logic [31:0] wb_dat_o;
  logic        pr_req = 0, pr_we = 0;
  logic [4:0]  pr_idx = '0;
  logic [31:0] pr_wdata = '0;
  logic        pr_ack;
  logic [31:0] pr_rdata;
  logic        pm_en, pm_we;
  logic [9:0]  pm_addr;
  logic [31:0] pm_wdata;
  logic [31:0] pm_rdata = '0;
  logic [7:0]  irq_i = '0;
  logic        irq_o, cpu_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int pm_en_running = 0;

  logic [31:0] pmem [0:1023];
  logic [31:0] mb_model [0:15];

  always #5 clk = ~clk;

  hir_regfile u_dut (
    .clk(clk), .rst(rst),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_ack_o(wb_ack), .wb_dat_o(wb_dat_o),
    .pr_req_i(pr_req), .pr_we_i(pr_we), .pr_idx_i(pr_idx), .pr_wdata_i(pr_wdata),
    .pr_ack_o(pr_ack), .pr_rdata_o(pr_rdata),
    .pm_en_o(pm_en), .pm_we_o(pm_we), .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata),
    .pm_rdata_i(pm_rdata), .irq_i(irq_i), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o)
  );

  // external program memory model
  always @(posedge clk) begin
    if (pm_en) begin
      if (pm_we) pmem[pm_addr] <= pm_wdata;
      pm_rdata <= pmem[pm_addr];
      if (!cpu_rst_o) pm_en_running++;
    end
  end

  function automatic logic [10:0] hreg(input int idx);
    return {1'b0, 10'(idx)};
  endfunction
  function automatic logic [10:0] hpm(input int a);
    return {1'b1, 10'(a)};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_dat_i = d;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
  endtask

  task automatic host_rd(input logic [10:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
    @(negedge clk);
    d = wb_dat_o; ack = wb_ack;
    wb_cyc = 0; wb_stb = 0;
  endtask

  task automatic proc_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    pr_req = 1; pr_we = 1; pr_idx = 5'(idx); pr_wdata = d;
    @(negedge clk);
    pr_req = 0; pr_we = 0;
  endtask

  task automatic proc_rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    pr_req = 1; pr_we = 0; pr_idx = 5'(idx);
    @(negedge clk);
    d = pr_rdata;
    pr_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) pmem[i] = 32'(i) ^ 32'hA5A5_0000;
    for (int i = 0; i < 16; i++) mb_model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    chk("R1 cpu_rst_o", 32'(cpu_rst_o), 32'd1);
    chk("R1 irq_o", 32'(irq_o), 32'd0);
    host_rd(hreg(5), d, a);  chk("R1 mailbox 5", d, 0);
    host_rd(hreg(16), d, a); chk("R1 run control", d, 0);
    host_rd(hreg(17), d, a); chk("R1 irq in word", d, 0);

    // R2 host write/read with ack timing
    host_wr(hreg(3), 32'hDEAD_BEEF); mb_model[3] = 32'hDEAD_BEEF;
    host_rd(hreg(3), d, a);
    chk("R2 ack in cycle after strobe", 32'(a), 1);
    chk("R2 read data", d, 32'hDEAD_BEEF);

    // R3 cross-port sharing
    proc_wr(7, 32'h1234_5678); mb_model[7] = 32'h1234_5678;
    host_rd(hreg(7), d, a); chk("R3 proc->host", d, 32'h1234_5678);
    host_wr(hreg(9), 32'h0BAD_F00D); mb_model[9] = 32'h0BAD_F00D;
    proc_rd(9, d); chk("R3 host->proc", d, 32'h0BAD_F00D);

    // R4 collision: processor wins
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = hreg(4); wb_dat_i = 32'h1111_1111;
    pr_req = 1; pr_we = 1; pr_idx = 5'd4; pr_wdata = 32'h2222_2222;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_we = 0; pr_req = 0; pr_we = 0;
    mb_model[4] = 32'h2222_2222;
    host_rd(hreg(4), d, a); chk("R4 collision keeps processor value", d, 32'h2222_2222);

    // R6 program memory while held in reset
    host_wr(hpm(18), 32'hCAFE_0018);
    host_rd(hpm(18), d, a); chk("R6 pm read back", d, 32'hCAFE_0018);
    host_rd(hpm(700), d, a); chk("R6 pm preset word", d, 32'd700 ^ 32'hA5A5_0000);

    // R5 release from reset, readback only bit 0
    host_wr(hreg(16), 32'hFFFF_FFFF);
    chk("R5 cpu_rst_o released", 32'(cpu_rst_o), 0);
    host_rd(hreg(16), d, a); chk("R5 run control readback", d, 1);

    // R7 program memory shut while running
    host_wr(hpm(18), 32'h5555_AAAA);
    host_rd(hpm(18), d, a);
    chk("R7 shut read is zero", d, 0);
    chk("R7 shut access acked", 32'(a), 1);
    chk("R7 no pm_en while running", 32'(pm_en_running), 0);

    // R12 processor cannot touch run control, unmapped space inert
    proc_wr(16, 32'h0);
    chk("R12 proc ctrl write ignored", 32'(cpu_rst_o), 0);
    host_wr(hreg(25), 32'h7777_7777);
    host_rd(hreg(25), d, a); chk("R12 unmapped reads zero", d, 0);
    host_wr(hreg(32), 32'h9999_9999);
    host_rd(hreg(32), d, a); chk("R12 aliased address reads zero", d, 0);
    host_rd(hreg(0), d, a);  chk("R12 mailbox 0 untouched", d, 0);

    // R5 reassert reset, R7 earlier write had no effect
    host_wr(hreg(16), 32'h0);
    chk("R5 cpu_rst_o reasserted", 32'(cpu_rst_o), 1);
    host_rd(hpm(18), d, a); chk("R7 shut write left memory", d, 32'hCAFE_0018);

    // R8 edge capture
    @(negedge clk) irq_i = 8'h04;
    @(negedge clk) irq_i = 8'h00;
    proc_rd(17, d); chk("R8 pulse latched", d, 32'h04);
    @(negedge clk) irq_i = 8'h20;
    repeat (3) @(negedge clk);
    proc_rd(17, d); chk("R8 level latched", d, 32'h24);
    proc_wr(17, 32'h20);
    repeat (2) @(negedge clk);
    proc_rd(17, d); chk("R8 held level does not re-set", d, 32'h04);
    // R9 clear from host, and set beats clear
    host_wr(hreg(17), 32'h04);
    proc_rd(17, d); chk("R9 host W1C", d, 32'h00);
    @(negedge clk);
    irq_i = 8'h22; pr_req = 1; pr_we = 1; pr_idx = 5'd17; pr_wdata = 32'h02;
    @(negedge clk);
    pr_req = 0; pr_we = 0;
    proc_rd(17, d); chk("R9 edge beats clear", d, 32'h02);
    irq_i = 8'h00;

    // R10 irq out set
    proc_wr(18, 32'h0);
    chk("R10 zero write no irq", 32'(irq_o), 0);
    proc_wr(18, 32'h3);
    chk("R10 irq_o high", 32'(irq_o), 1);
    proc_wr(18, 32'h4);
    host_rd(hreg(18), d, a); chk("R10 OR accumulation", d, 32'h7);
    // R11 host W1C
    host_wr(hreg(18), 32'h3);
    host_rd(hreg(18), d, a); chk("R11 partial clear", d, 32'h4);
    chk("R11 irq_o still high", 32'(irq_o), 1);
    host_wr(hreg(18), 32'h4);
    chk("R11 irq_o low after clear", 32'(irq_o), 0);

    // R3 random shared-mailbox traffic
    for (int i = 0; i < 80; i++) begin
      int idx;
      logic [31:0] v;
      idx = int'($urandom % 16);
      v = $urandom;
      case ($urandom % 4)
        0: begin host_wr(hreg(idx), v); mb_model[idx] = v; end
        1: begin proc_wr(idx, v); mb_model[idx] = v; end
        2: begin host_rd(hreg(idx), d, a); chk("R3 random host read", d, mb_model[idx]); end
        default: begin proc_rd(idx, d); chk("R3 random proc read", d, mb_model[idx]); end
      endcase
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule